// File: doc/BRIEF.md
# Cascadable presettable binary counter

This block is a synchronous up-counter made of one or more 4-bit digit stages. It has a parallel preset, an active-low clear and two count enables. Each digit advances on the rising clock edge. Each digit also makes a combinational carry that permits the digit above it to count. With the defaults, two digits are chained into an 8-bit counter. The final carry is brought out so that further instances can be chained outside the block.

The two enables have different jobs. `cnt_en` is a plain count permission and is shared by every digit. `chain_en` also permits counting, but it is the only input that gates the carry. Inside the chain, the carry of each digit drives the `chain_en` of the next digit, so the whole word steps by exactly one on each enabled edge. A build parameter selects the clear style. With it, the clear either acts at once, without a clock, or waits for the next rising edge.

The priority order is clear, then preset, then count.

Top module: `wide_preset_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, after that edge `count` is all zeros and `carry_out` is low.
- R2: When `ASYNC_RST` is 1, `count` goes to zero as soon as `rst_n` falls, with no clock edge. When `ASYNC_RST` is 0, a falling `rst_n` leaves `count` unchanged until the next rising edge, which clears it.
- R3: Clear wins over preset and over counting. With `rst_n` low and `load_n` low at an edge, `count` still becomes zero.
- R4: With `rst_n` high and `load_n` low at a rising edge, `preset` is copied into `count`, whatever the enables are. Bit 0 of both `preset` and `count` is the least significant bit.
- R5: With `rst_n`, `load_n`, `cnt_en` and `chain_en` all high at a rising edge, `count` increases by one.
- R6: With `load_n` high and either `cnt_en` or `chain_en` low, `count` keeps its value.
- R7: An enabled count edge from the all-ones value gives zero.
- R8: `carry_out` is the AND of `chain_en` and every `count` bit. It is combinational and does not depend on `cnt_en`.
- R9: A digit's carry feeds the next digit's `chain_en`. When a lower digit rolls from 1111 to 0000, the digit above it steps on the same edge. A lower digit that is all ones does not by itself raise `carry_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear; timing set by `ASYNC_RST` |
| load_n | input | 1 | Active-low synchronous preset |
| cnt_en | input | 1 | Count permission shared by all digits |
| chain_en | input | 1 | Count permission that also gates the carry |
| preset | input | DIGIT_W*STAGES | Parallel preset value, bit 0 least significant |
| count | output | DIGIT_W*STAGES | Counter value, bit 0 least significant |
| carry_out | output | 1 | High when `chain_en` is high and `count` is all ones |

## Verification
The assertions check these properties on every cycle:
- the clear result one edge after a low `rst_n`;
- preset copying, single-step increments, holding and rollover in each digit;
- the single-step behaviour of the whole chained word;
- the exact condition under which `carry_out` is high.

Some behaviour only the bench's scenarios can show, because the assertions sample only at clock edges:
- In asynchronous mode, `rst_n` falling between edges clears `count` before any edge arrives.
- In synchronous mode, the same fall leaves `count` unchanged until the next edge.
- `carry_out` follows `chain_en` between edges while `cnt_en` stays low.

The bench also shows the carry rippling across digits at the 0x0F to 0x10 boundary.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } act_e;
endpackage

// File: rtl/pc_next.sv
module pc_next
  import pc_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] q,
  input  logic [DIGIT_W-1:0] preset,
  input  logic               load_n,
  input  logic               cnt_en,
  input  logic               chain_en,
  output logic [DIGIT_W-1:0] d,
  output logic               ce
);
  act_e act;

  // preset outranks counting
  always_comb begin
    if (!load_n)                act = ACT_LOAD;
    else if (cnt_en && chain_en) act = ACT_STEP;
    else                        act = ACT_HOLD;
  end

  always_comb begin
    case (act)
      ACT_LOAD: d = preset;
      ACT_STEP: d = q + DIGIT_W'(1);
      default:  d = q;
    endcase
    ce = (act != ACT_HOLD);
  end
endmodule

// File: rtl/pc_state_reg.sv
module pc_state_reg #(
  parameter int DIGIT_W   = 4,
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce,
  input  logic [DIGIT_W-1:0] d,
  output logic [DIGIT_W-1:0] q
);
  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (ce) q <= d;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ce) q <= d;
      end
    end
  endgenerate

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (q == '0)); // R1
endmodule

// File: rtl/pc_stage.sv
module pc_stage #(
  parameter int DIGIT_W   = 4,
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_n,
  input  logic               cnt_en,
  input  logic               chain_en,
  input  logic [DIGIT_W-1:0] preset,
  output logic [DIGIT_W-1:0] q,
  output logic               carry
);
  logic [DIGIT_W-1:0] d;
  logic               ce;

  pc_next #(.DIGIT_W(DIGIT_W)) i_next (
    .q(q), .preset(preset), .load_n(load_n), .cnt_en(cnt_en),
    .chain_en(chain_en), .d(d), .ce(ce)
  );

  pc_state_reg #(.DIGIT_W(DIGIT_W), .ASYNC_RST(ASYNC_RST)) i_reg (
    .clk(clk), .rst_n(rst_n), .ce(ce), .d(d), .q(q)
  );

  // carry depends on chain_en only, never on cnt_en
  assign carry = chain_en & (&q);

  AST_RESET_WINS: assert property (@(posedge clk)
    (!rst_n && !load_n) |=> (q == '0)); // R3
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (q == $past(preset))); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && cnt_en && chain_en) |=> (q == DIGIT_W'($past(q) + DIGIT_W'(1)))); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(cnt_en && chain_en)) |=> $stable(q)); // R6
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && cnt_en && chain_en && (q == '1)) |=> (q == '0)); // R7
endmodule

// File: rtl/wide_preset_counter.sv
module wide_preset_counter #(
  parameter int DIGIT_W   = 4,
  parameter int STAGES    = 2,
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_n,
  input  logic                        cnt_en,
  input  logic                        chain_en,
  input  logic [DIGIT_W*STAGES-1:0]   preset,
  output logic [DIGIT_W*STAGES-1:0]   count,
  output logic                        carry_out
);
  localparam int TOTAL_W = DIGIT_W * STAGES;

  logic [STAGES:0] t_chain;
  assign t_chain[0] = chain_en;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_digit
      pc_stage #(.DIGIT_W(DIGIT_W), .ASYNC_RST(ASYNC_RST)) i_stage (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en(cnt_en),
        .chain_en(t_chain[g]),
        .preset(preset[g*DIGIT_W +: DIGIT_W]),
        .q(count[g*DIGIT_W +: DIGIT_W]),
        .carry(t_chain[g+1])
      );
    end
  endgenerate

  assign carry_out = t_chain[STAGES];

  AST_CARRY_MAX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> (chain_en && (count == '1))); // R8
  AST_CARRY_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && (count == '1)) |-> carry_out); // R8
  AST_WIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && cnt_en && chain_en) |=> (count == TOTAL_W'($past(count) + TOTAL_W'(1)))); // R9
endmodule

// File: tb/test_wide_preset_counter.sv
module test_wide_preset_counter;
  localparam int DW = 4;
  localparam int NS = 2;
  localparam int W  = DW * NS;

  logic         clk = 1'b0;
  logic         rst_n, load_n, cnt_en, chain_en;
  logic [W-1:0] preset;
  logic [W-1:0] count_a, count_s;
  logic         carry_a, carry_s;
  int           total = 0;
  int           bad   = 0;

  always #2 clk = ~clk;

  wide_preset_counter #(.DIGIT_W(DW), .STAGES(NS), .ASYNC_RST(1'b1)) i_wide_preset_counter (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en(cnt_en), .chain_en(chain_en),
    .preset(preset), .count(count_a), .carry_out(carry_a)
  );

  wide_preset_counter #(.DIGIT_W(DW), .STAGES(NS), .ASYNC_RST(1'b0)) i_wide_preset_counter_sync (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en(cnt_en), .chain_en(chain_en),
    .preset(preset), .count(count_s), .carry_out(carry_s)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_both(input string req, input logic [W-1:0] exp);
    chk({req, " async"}, count_a, exp);
    chk({req, " sync"},  count_s, exp);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_load(input logic [W-1:0] v);
    load_n = 1'b0; preset = v;
    tick();
    load_n = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; load_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b1; preset = '0;
    tick(); tick();
    chk_both("R1 clear", '0);
    chk("R1 carry async", W'(carry_a), '0);
    chk("R1 carry sync",  W'(carry_s), '0);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_load();
    cnt_en = 1'b1; chain_en = 1'b1;
    do_load(8'hA5);
    chk_both("R4 load with enables high", 8'hA5);
    cnt_en = 1'b0; chain_en = 1'b0;
    do_load(8'h3C);
    chk_both("R4 load with enables low", 8'h3C);
  endtask

  task automatic t_hold();
    cnt_en = 1'b0; chain_en = 1'b1;
    tick(); tick();
    chk_both("R6 hold cnt_en low", 8'h3C);
    cnt_en = 1'b1; chain_en = 1'b0;
    tick();
    chk_both("R6 hold chain_en low", 8'h3C);
  endtask

  task automatic t_count();
    cnt_en = 1'b0; chain_en = 1'b0;
    do_load(8'h0D);
    cnt_en = 1'b1; chain_en = 1'b1;
    tick();
    chk_both("R5 step", 8'h0E);
    tick();
    chk_both("R5 step", 8'h0F);
    chk("R9 low digit full no carry_out", W'(carry_a), '0);
    tick();
    chk_both("R9 ripple into upper digit", 8'h10);
    tick();
    chk_both("R5 step", 8'h11);
  endtask

  task automatic t_carry();
    cnt_en = 1'b0; chain_en = 1'b0;
    do_load(8'hFE);
    chain_en = 1'b1; #1;
    chk("R8 carry low below max", W'(carry_a), '0);
    cnt_en = 1'b1;
    tick();
    chk_both("R5 step to max", 8'hFF);
    cnt_en = 1'b0; #1;
    chk("R8 carry high with cnt_en low", W'(carry_a), 8'h01);
    chain_en = 1'b0; #1;
    chk("R8 carry held low by chain_en", W'(carry_s), '0);
    chain_en = 1'b1; cnt_en = 1'b1;
    tick();
    chk_both("R7 wrap", 8'h00);
    chk("R8 carry after wrap", W'(carry_a), '0);
  endtask

  task automatic t_reset_timing();
    cnt_en = 1'b0; chain_en = 1'b0;
    do_load(8'h3C);
    tick();
    rst_n = 1'b0; #1;
    chk("R2 async clears between edges", count_a, 8'h00);
    chk("R2 sync waits for edge", count_s, 8'h3C);
    tick();
    chk("R2 sync clears at edge", count_s, 8'h00);
    load_n = 1'b0; preset = 8'h77; cnt_en = 1'b1; chain_en = 1'b1;
    tick();
    chk_both("R3 clear beats load", 8'h00);
    rst_n = 1'b1;
    tick();
    chk_both("R4 load after clear", 8'h77);
    load_n = 1'b1;
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog all actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_hold();
    t_count();
    t_carry();
    t_reset_timing();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule